// File: doc/BRIEF.md
# Post-Reset Protected Configuration Register Bank

This block holds eight 8-bit configuration registers behind a plain synchronous bus made of an address, a write strobe, write data and read data. Each bit has its own write rule. Some bits are always writable. Some accept one write, and only while a short window after reset is still open. Some accept one write at any time. One register, the block-protect mask, can set bits freely but can clear them only while the window is open.

A special-mode flag removes every one of these limits, for test and bootstrap use. The bank latches this flag, together with a mode-A flag, from two strap pins while reset is held. Reading a register always returns its current contents, whatever the write rules did to it.

The block uses three pieces of state to decide write permission: a saturating counter of clock cycles since reset release, a sticky "written" flag for each register address, and the captured mode flags. A controller turns these into a small struct of strobes. A register datapath uses that struct to decide, bit by bit, whether each write lands.

Top module: `cfgprot_bank`

## Requirements
- R1: A window counter starts at 0 on the first clock edge after reset release and adds one on each edge, saturating at 64. A write sampled on edges 0 to 63 after release is inside the window. A write sampled on edge 64 or later is outside it.
- R2: While `rstN` is low, `specialMode` is loaded with the inverse of `modeStrapB` and `modeAFlag` with `modeStrapA`. After release, changes on the strap pins have no effect on either flag.
- R3: Timer mask register (address 0). Bits 1:0 take one write, and only inside the window, when `specialMode` is 0. Bits 7:2 are always writable.
- R4: Option register (address 1). Bits 5, 4, 2, 1 and 0 take one write, and only inside the window, when `specialMode` is 0. Bits 7, 6 and 3 are always writable.
- R5: Memory map register (address 2). The whole register takes one write, and only inside the window, when `specialMode` is 0. After that it is read-only.
- R6: Block-protect register (address 3). Its reset value is 0xFF. Writing a 1 to a bit always sets it. A bit goes from 1 to 0 only inside the window or when `specialMode` is 1. Outside those conditions the stored value becomes old OR data.
- R7: Storage map register (address 4). The whole register is write-once at any time when `specialMode` is 0.
- R8: Write-once at any time when `specialMode` is 0: bit 4 of the second option register (address 5), and bits 5:2 of each of the two timer control registers (addresses 6 and 7). The other bits of these registers are always writable.
- R9: When `specialMode` is 1, every bit of every register is writable on every write, and a write to the block-protect register stores the data exactly.
- R10: After reset, every register except block-protect reads 0. `busRdata` shows the register selected by `busAddr` in the same cycle, with no added latency.
- R11: Any write to an address sets that address's written flag, even when the data equals the current contents. Only reset clears the flag. Later writes to the once-only bits of that register are then ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset; strap pins are sampled while it is low |
| modeStrapA | input | 1 | Mode strap A, copied into `modeAFlag` during reset |
| modeStrapB | input | 1 | Mode strap B; a low level during reset selects special mode |
| busAddr | input | 3 | Register address for both read and write |
| busWe | input | 1 | Write strobe, sampled on the rising clock edge |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Contents of the addressed register |
| specialMode | output | 1 | Captured special-mode flag |
| modeAFlag | output | 1 | Captured mode-A flag |

## Verification
Two things can happen on the same edge: the window closing, and the first write to a windowed register, which both lands data and sets that register's written flag. The bench provokes this by placing a first write to the memory map register exactly on edge 63 in one reset run and on edge 64 in another. It expects the first to land and the second to leave the reset value.

A set and a clear can also arrive together, in one write to the block-protect register after the window. The bench judges that case by expecting old OR data.

Constrained-random writes then sweep every address across the window boundary, in both normal and special mode, against a bench model built from the per-bit rules.

// File: rtl/cfgprot_pkg.sv
package cfgprot_pkg;
  localparam int DATA_W   = 8;
  localparam int NUM_REGS = 8;
  localparam int ADDR_W   = $clog2(NUM_REGS);

  localparam int ADDR_TMR_MASK = 0;
  localparam int ADDR_SYS_OPT  = 1;
  localparam int ADDR_MEM_MAP  = 2;
  localparam int ADDR_BLK_PROT = 3;
  localparam int ADDR_EE_MAP   = 4;
  localparam int ADDR_OPT2     = 5;
  localparam int ADDR_TCTL_A   = 6;
  localparam int ADDR_TCTL_B   = 7;

  typedef struct packed {
    logic [NUM_REGS-1:0] regSel;    // one-hot write strobe per register
    logic                inWindow;  // post-reset window still open
    logic                special;   // captured special-mode flag
    logic [NUM_REGS-1:0] lockDone;  // sticky written flag per register
  } ctlStrobe_t;

  // Bits that accept one write, and only inside the window
  function automatic logic [DATA_W-1:0] windowOnceMask(int idx);
    case (idx)
      ADDR_TMR_MASK: return DATA_W'(8'h03);
      ADDR_SYS_OPT:  return DATA_W'(8'h37);
      ADDR_MEM_MAP:  return {DATA_W{1'b1}};
      default:       return '0;
    endcase
  endfunction

  // Bits that accept one write at any time
  function automatic logic [DATA_W-1:0] onceOnlyMask(int idx);
    case (idx)
      ADDR_EE_MAP: return {DATA_W{1'b1}};
      ADDR_OPT2:   return DATA_W'(8'h10);
      ADDR_TCTL_A: return DATA_W'(8'h3C);
      ADDR_TCTL_B: return DATA_W'(8'h3C);
      default:     return '0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] resetValue(int idx);
    return (idx == ADDR_BLK_PROT) ? {DATA_W{1'b1}} : '0;
  endfunction
endpackage

// File: rtl/cfgprot_ctrl.sv
module cfgprot_ctrl
  import cfgprot_pkg::*;
#(
  parameter int WINDOW_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeStrapA,
  input  logic              modeStrapB,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output ctlStrobe_t        strobe,
  output logic              specialMode,
  output logic              modeAFlag
);
  localparam int CNT_W = $clog2(WINDOW_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WINDOW_CYCLES);

  logic [CNT_W-1:0]    winCnt;
  logic                specialQ;
  logic                modeAQ;
  logic [NUM_REGS-1:0] lockDone;
  logic [NUM_REGS-1:0] regSel;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
    assign regSel[i] = busWe && (busAddr == ADDR_W'(i));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winCnt   <= '0;
      specialQ <= ~modeStrapB;
      modeAQ   <= modeStrapA;
      lockDone <= '0;
    end else begin
      if (winCnt != CNT_MAX) winCnt <= winCnt + 1'b1;
      lockDone <= lockDone | regSel;
    end
  end

  always_comb begin
    strobe.regSel   = regSel;
    strobe.inWindow = (winCnt < CNT_MAX);
    strobe.special  = specialQ;
    strobe.lockDone = lockDone;
  end

  assign specialMode = specialQ;
  assign modeAFlag   = modeAQ;

  // R1
  win_cnt_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    winCnt <= CNT_MAX);

  // R1
  win_no_reopen_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.inWindow |=> !strobe.inWindow);

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> ($stable(specialQ) && $stable(modeAQ)));

  // R11
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> ((lockDone & $past(lockDone)) == $past(lockDone)));
endmodule

// File: rtl/cfgprot_regs.sv
module cfgprot_regs
  import cfgprot_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  ctlStrobe_t        strobe,
  output logic [DATA_W-1:0] busRdata
);
  logic [DATA_W-1:0] regQ [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [DATA_W-1:0] WIN_M  = windowOnceMask(i);
    localparam logic [DATA_W-1:0] ONCE_M = onceOnlyMask(i);
    logic [DATA_W-1:0] nextVal;

    if (i == ADDR_BLK_PROT) begin : g_prot
      // set always allowed; clear only in window or special mode
      always_comb begin
        if (strobe.special || strobe.inWindow) nextVal = busWdata;
        else                                  nextVal = regQ[i] | busWdata;
      end
    end else begin : g_std
      logic [DATA_W-1:0] bitEn;
      always_comb begin
        bitEn = ~(WIN_M | ONCE_M);
        if (strobe.special) begin
          bitEn = '1;
        end else if (!strobe.lockDone[i]) begin
          bitEn = bitEn | ONCE_M;
          if (strobe.inWindow) bitEn = bitEn | WIN_M;
        end
        nextVal = (regQ[i] & ~bitEn) | (busWdata & bitEn);
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN)                 regQ[i] <= resetValue(i);
      else if (strobe.regSel[i]) regQ[i] <= nextVal;
    end
  end

  assign busRdata = regQ[busAddr];

  // R3
  tmr_low_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.special && (!strobe.inWindow || strobe.lockDone[ADDR_TMR_MASK]))
    |=> $stable(regQ[ADDR_TMR_MASK][1:0]));

  // R5
  mem_map_ro_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.special && !strobe.inWindow) |=> $stable(regQ[ADDR_MEM_MAP]));

  // R6
  prot_no_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.special && !strobe.inWindow) |=>
    ((regQ[ADDR_BLK_PROT] & $past(regQ[ADDR_BLK_PROT])) == $past(regQ[ADDR_BLK_PROT])));

  // R7
  ee_map_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.special && strobe.lockDone[ADDR_EE_MAP]) |=> $stable(regQ[ADDR_EE_MAP]));
endmodule

// File: rtl/cfgprot_bank.sv
module cfgprot_bank
  import cfgprot_pkg::*;
#(
  parameter int WINDOW_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeStrapA,
  input  logic              modeStrapB,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              specialMode,
  output logic              modeAFlag
);
  ctlStrobe_t strobe;

  cfgprot_ctrl #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .modeStrapA(modeStrapA), .modeStrapB(modeStrapB),
    .busAddr(busAddr), .busWe(busWe), .strobe(strobe),
    .specialMode(specialMode), .modeAFlag(modeAFlag)
  );

  cfgprot_regs u_regs (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .strobe(strobe), .busRdata(busRdata)
  );
endmodule

// File: tb/cfgprot_bank_bench.sv
`timescale 1ns/100ps
module cfgprot_bank_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       modeStrapA = 1'b0, modeStrapB = 1'b1;
  logic [2:0] busAddr = '0;
  logic       busWe = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       specialMode, modeAFlag;

  int checks = 0, fails = 0, edgeCount = 0;
  bit finished = 0;
  logic [7:0] expReg [8];
  bit         doneM  [8];
  bit         spM;

  always #2 clk = ~clk;  // 250 MHz
  always @(posedge clk) if (rstN) edgeCount++;

  cfgprot_bank u_cfgprot_bank (
    .clk(clk), .rstN(rstN), .modeStrapA(modeStrapA), .modeStrapB(modeStrapB),
    .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata), .busRdata(busRdata),
    .specialMode(specialMode), .modeAFlag(modeAFlag)
  );

  // per-bit rules taken from the requirements
  function automatic logic [7:0] winBits(int a);
    case (a) 0: return 8'h03; 1: return 8'h37; 2: return 8'hFF; default: return 8'h00; endcase
  endfunction
  function automatic logic [7:0] onceBits(int a);
    case (a) 4: return 8'hFF; 5: return 8'h10; 6, 7: return 8'h3C; default: return 8'h00; endcase
  endfunction
  function automatic logic [7:0] predict(int a, logic [7:0] cur, logic [7:0] d,
                                         bit win, bit done, bit sp);
    logic [7:0] en;
    if (a == 3) return (sp || win) ? d : (cur | d);
    if (sp) return d;
    en = ~(winBits(a) | onceBits(a));
    if (!done) en = en | onceBits(a) | (win ? winBits(a) : 8'h00);
    return (cur & ~en) | (d & en);
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (edge %0d)", tag, act, exp, edgeCount);
    end
  endtask

  task automatic checkReg(int a, string tag);
    busAddr = 3'(a);
    #0.5;
    check(tag, busRdata, expReg[a]);
  endtask

  task automatic doReset(bit strapA, bit strapB);
    @(negedge clk);
    rstN = 1'b0; busWe = 1'b0;
    modeStrapA = strapA; modeStrapB = strapB;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    edgeCount = 0;
    spM = !strapB;
    for (int i = 0; i < 8; i++) begin
      expReg[i] = (i == 3) ? 8'hFF : 8'h00;
      doneM[i]  = 0;
    end
  endtask

  // called at a negedge; the write lands on the next posedge
  task automatic busWrite(int a, logic [7:0] d, string tag);
    bit win;
    busAddr = 3'(a); busWdata = d; busWe = 1'b1;
    win = (edgeCount < 64);
    @(negedge clk);
    busWe = 1'b0;
    expReg[a] = predict(a, expReg[a], d, win, doneM[a], spM);
    doneM[a]  = 1;
    checkReg(a, tag);
  endtask

  task automatic waitEdge(int n);
    while (edgeCount < n) @(negedge clk);
  endtask

  task automatic randomPhase(int n, string tag);
    for (int k = 0; k < n; k++) begin
      if ($urandom_range(3) == 0) @(negedge clk);
      busWrite(int'($urandom_range(7)), 8'($urandom), tag);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // normal mode: reset values (R10) and mode capture (R2)
    doReset(1'b1, 1'b1);
    for (int i = 0; i < 8; i++) checkReg(i, "R10 reset value");
    check("R2 special flag", {7'd0, specialMode}, 8'd0);
    check("R2 modeA flag", {7'd0, modeAFlag}, 8'd1);
    modeStrapA = 1'b0; modeStrapB = 1'b0;
    repeat (2) @(negedge clk);
    check("R2 straps ignored after reset (special)", {7'd0, specialMode}, 8'd0);
    check("R2 straps ignored after reset (modeA)", {7'd0, modeAFlag}, 8'd1);
    // R3 timer mask
    busWrite(0, 8'hFF, "R3 first in-window write");
    busWrite(0, 8'h00, "R3 low bits locked, high bits free");
    // R4 option register
    busWrite(1, 8'hFF, "R4 first write");
    busWrite(1, 8'h00, "R4 only bits 7,6,3 clear");
    // R6 clear inside window
    busWrite(3, 8'h0F, "R6 clear in window");
    // R11 write of unchanged data locks
    busWrite(4, 8'h00, "R11 same-value write");
    busWrite(4, 8'h5A, "R7 storage map locked");
    // R8 once bits
    busWrite(5, 8'hFF, "R8 opt2 first write");
    busWrite(5, 8'h00, "R8 opt2 bit4 held");
    busWrite(6, 8'hC3, "R8 tctlA first write");
    busWrite(6, 8'h3C, "R8 tctlA bits5:2 held");
    busWrite(7, 8'hFF, "R8 tctlB first write");
    busWrite(7, 8'h00, "R8 tctlB bits5:2 held");
    // R1 window edge 63: first write to memory map lands
    waitEdge(63);
    busWrite(2, 8'hA5, "R1 write on edge 63");
    check("R5 value after edge-63 write", busRdata, 8'hA5);
    // R6 after window: set allowed, clear refused
    busWrite(3, 8'hF0, "R6 set+clear after window");
    busWrite(3, 8'h00, "R6 clear after window ignored");
    randomPhase(150, "R3-R8 random normal");

    // fresh reset: first write on edge 64 is refused
    doReset(1'b0, 1'b1);
    check("R2 modeA captured low", {7'd0, modeAFlag}, 8'd0);
    waitEdge(64);
    busWrite(2, 8'h3C, "R1 write on edge 64 refused");
    busWrite(0, 8'hFF, "R3 out-of-window");
    busWrite(1, 8'hFF, "R4 out-of-window");
    busWrite(4, 8'h77, "R7 first late write");
    busWrite(4, 8'h11, "R7 second late write");

    // special mode: everything free (R9)
    doReset(1'b0, 1'b0);
    check("R2 special captured", {7'd0, specialMode}, 8'd1);
    waitEdge(70);
    busWrite(2, 8'h12, "R9 mem map late");
    busWrite(2, 8'h34, "R9 mem map again");
    busWrite(3, 8'h00, "R9 prot clear late");
    busWrite(4, 8'h55, "R9 storage map");
    busWrite(4, 8'hAA, "R9 storage map again");
    modeStrapB = 1'b1;
    @(negedge clk);
    check("R2 special held after strap change", {7'd0, specialMode}, 8'd1);
    randomPhase(150, "R9 random special");

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule